// File: doc/BRIEF.md
# Fractional Baud Rate Prescaler

This block turns a system clock into a one-cycle baud tick for a serial framer. An internal divider first reduces the system clock to a reference enable (48 MHz divided by 16 gives 3 MHz). The baud period is then a whole number `n` of reference enables plus a fraction `k/8`. The fraction is realised by lengthening `k` out of every eight tick periods by one reference enable. An accumulator spreads the long periods evenly across each group of eight.

Two integer values bypass the fractional path. A divisor of 0 gives a tick on every reference enable (3 Mbaud). A divisor of 1 gives a tick every 24 system clocks, which is 2 Mbaud from a 48 MHz clock. The fraction code is ignored in both of these cases. A separate wide flag turns an integer field of 0 into the largest divisor, 2^INT_W (16384 by default). A divisor is taken in with a single `load` strobe. Each load restarts the reference divider, the period counter and the fraction accumulator, so the first tick comes a fixed number of cycles after the load.

The controller has four states. `ST_OFF` is the reset state and emits nothing. `ST_FULL` ticks on every reference enable. `ST_FAST` ticks on the direct divide-by-FAST_DIV enable. `ST_FRAC` counts reference enables against `n` or `n+1`. A `load` moves the controller from any state to the state that matches the decoded divisor:
- int 0 without wide → `ST_FULL`
- int 1 → `ST_FAST`
- any other value, or int 0 with wide → `ST_FRAC`

Without a load, the state does not change.

Top module: `baud_prescaler`

## Requirements
- R1: After reset, and until the first `load`, `tick` stays low.
- R2: With an integer field of 0 and `div_wide` low, `tick` pulses once every REF_DIV clock cycles, and `div_frac` has no effect.
- R3: With an integer field of 1, `tick` pulses once every FAST_DIV clock cycles, and `div_frac` has no effect.
- R4: With an integer field `n` of 2 or more and a fraction code of 0, consecutive ticks are exactly `n*REF_DIV` clock cycles apart.
- R5: With fraction code `k` (a 3-bit field meaning k/8), tick period number `j` after a load (j = 1, 2, ...) lasts `(n+1)*REF_DIV` cycles when floor(j*k/8) differs from floor((j-1)*k/8), and `n*REF_DIV` cycles otherwise. As a result, every eight consecutive periods total `(8n+k)*REF_DIV` cycles.
- R6: With an integer field of 0 and `div_wide` high, the divisor is 2^INT_W. When the integer field is nonzero, `div_wide` has no effect.
- R7: `tick` is never high on two consecutive cycles.
- R8: A `load` sampled on clock edge E0 restarts the timing. The first tick is high in the cycle after edge E0 + L, where L is REF_DIV for the 3 Mbaud rate, FAST_DIV for the 2 Mbaud rate and `n*REF_DIV` otherwise. This holds even when the load comes in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Takes in the divisor fields on this edge |
| div_int | input | INT_W | Integer part of the divisor |
| div_frac | input | 3 | Fraction code k, meaning k/8 |
| div_wide | input | 1 | Makes an integer field of 0 mean 2^INT_W |
| tick | output | 1 | One-cycle baud tick |

## Verification
The bench builds the block with INT_W=4, REF_DIV=4 and FAST_DIV=6. The 3:2 ratio between the two special rates stays the same as in the default build. The wide divisor (16 reference periods, 64 cycles) can be measured several times in a short run. The fractional pattern is checked period by period over sixteen periods for codes 1, 4 and 7. The reload case checks that a load in the middle of a period restarts the first-tick latency.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int FRAC_W = 3;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_FULL = 2'd1,
        ST_FAST = 2'd2,
        ST_FRAC = 2'd3
    } bp_state_t;
endpackage

// File: rtl/bp_clk_div.sv
module bp_clk_div #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic en
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign en = (cnt == LAST);

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/bp_frac_step.sv
module bp_frac_step
    import bp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic              advance,
    output logic              stretch
);
    logic [FRAC_W-1:0] k_q;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;

    assign sum = {1'b0, acc} + {1'b0, k_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_q     <= '0;
            acc     <= '0;
            stretch <= 1'b0;
        end else if (load) begin
            k_q     <= frac_in;
            acc     <= frac_in;
            stretch <= 1'b0;
        end else if (advance) begin
            acc     <= sum[FRAC_W-1:0];
            stretch <= sum[FRAC_W];
        end
    end

    assert_zero_frac_flat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (k_q == '0) |-> !stretch);
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import bp_pkg::*;
#(
    parameter int INT_W    = 14,
    parameter int REF_DIV  = 16,
    parameter int FAST_DIV = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              div_wide,
    output logic              tick
);
    localparam int CW = INT_W + 1;
    localparam logic [CW-1:0] WIDE_N = CW'(1) << INT_W;

    bp_state_t     state, state_nx;
    logic [CW-1:0] n_q, n_dec;
    logic [CW-1:0] pcnt, last;
    logic          ref_en, fast_en, stretch;
    logic          tick_d, tick_q;

    bp_clk_div #(.DIV(REF_DIV)) u_ref (
        .clk(clk), .rst_n(rst_n), .restart(load), .en(ref_en)
    );

    bp_clk_div #(.DIV(FAST_DIV)) u_fast (
        .clk(clk), .rst_n(rst_n), .restart(load), .en(fast_en)
    );

    bp_frac_step u_frac (
        .clk(clk), .rst_n(rst_n), .load(load), .frac_in(div_frac),
        .advance(tick_d && (state == ST_FRAC)), .stretch(stretch)
    );

    always_comb begin
        if (div_int == '0 && div_wide) n_dec = WIDE_N;
        else                           n_dec = {1'b0, div_int};
    end

    always_comb begin
        state_nx = state;
        if (load) begin
            if (div_int == '0 && !div_wide)         state_nx = ST_FULL;
            else if (div_int == INT_W'(1))          state_nx = ST_FAST;
            else                                    state_nx = ST_FRAC;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    assign last = n_q + CW'(stretch) - CW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q  <= '0;
            pcnt <= '0;
        end else if (load) begin
            n_q  <= n_dec;
            pcnt <= '0;
        end else if (state == ST_FRAC && ref_en) begin
            if (pcnt == last) pcnt <= '0;
            else              pcnt <= pcnt + 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            ST_OFF:  tick_d = 1'b0;
            ST_FULL: tick_d = ref_en;
            ST_FAST: tick_d = fast_en;
            ST_FRAC: tick_d = ref_en && (pcnt == last);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_d && !load;
    end

    assign tick = tick_q;

    assert_off_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> !tick_q);
    assert_full_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && ref_en && !load) |=> tick_q);
    assert_fast_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAST && fast_en && !load) |=> tick_q);
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FRAC) |-> (pcnt <= n_q));
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);
endmodule

// File: tb/baud_prescaler_bench.sv
module baud_prescaler_bench;
    localparam int INT_W = 4;
    localparam int RD    = 4;
    localparam int FD    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic [INT_W-1:0] div_int = '0;
    logic [2:0] div_frac = '0;
    logic div_wide = 1'b0;
    logic tick;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    baud_prescaler #(.INT_W(INT_W), .REF_DIV(RD), .FAST_DIV(FD)) u_baud_prescaler (
        .clk(clk), .rst_n(rst_n), .load(load), .div_int(div_int),
        .div_frac(div_frac), .div_wide(div_wide), .tick(tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_load(input int n, input int k, input bit wide);
        @(negedge clk);
        div_int = INT_W'(n); div_frac = 3'(k); div_wide = wide; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic next_tick(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!tick && cyc < 2000);
    endtask

    task automatic t_reset_R1();
        int seen = 0;
        repeat (40) begin
            @(negedge clk);
            if (tick) seen++;
        end
        check(seen == 0, "R1", seen, 0);
    endtask

    task automatic t_full_R2();
        int c;
        do_load(0, 5, 1'b0);
        next_tick(c); check(c == RD, "R2/R8 latency", c, RD);
        repeat (3) begin next_tick(c); check(c == RD, "R2", c, RD); end
    endtask

    task automatic t_fast_R3();
        int c;
        do_load(1, 3, 1'b1);
        next_tick(c); check(c == FD, "R3/R8 latency", c, FD);
        repeat (3) begin next_tick(c); check(c == FD, "R3", c, FD); end
    endtask

    task automatic t_int_R4(input int n);
        int c;
        do_load(n, 0, 1'b0);
        next_tick(c); check(c == n * RD, "R4/R8 latency", c, n * RD);
        repeat (3) begin next_tick(c); check(c == n * RD, "R4", c, n * RD); end
    endtask

    task automatic t_frac_R5(input int n, input int k);
        int c, e, tot;
        tot = 0;
        do_load(n, k, 1'b0);
        for (int j = 1; j <= 16; j++) begin
            next_tick(c);
            e = (((j * k) / 8) != (((j - 1) * k) / 8)) ? (n + 1) * RD : n * RD;
            check(c == e, "R5 period", c, e);
            if (j > 8) tot += c;
        end
        check(tot == (8 * n + k) * RD, "R5 group", tot, (8 * n + k) * RD);
    endtask

    task automatic t_wide_R6();
        int c;
        do_load(0, 0, 1'b1);
        next_tick(c); check(c == 16 * RD, "R6 latency", c, 16 * RD);
        next_tick(c); check(c == 16 * RD, "R6", c, 16 * RD);
        do_load(3, 0, 1'b1);
        next_tick(c); check(c == 3 * RD, "R6 ignored", c, 3 * RD);
        next_tick(c); check(c == 3 * RD, "R6 ignored", c, 3 * RD);
    endtask

    task automatic t_pulse_R7();
        int c;
        do_load(0, 0, 1'b0);
        next_tick(c);
        @(negedge clk);
        check(tick == 1'b0, "R7", int'(tick), 0);
        do_load(1, 0, 1'b0);
        next_tick(c);
        @(negedge clk);
        check(tick == 1'b0, "R7", int'(tick), 0);
    endtask

    task automatic t_reload_R8();
        int c;
        do_load(5, 0, 1'b0);
        repeat (7) @(negedge clk);
        do_load(2, 0, 1'b0);
        next_tick(c); check(c == 2 * RD, "R8", c, 2 * RD);
        do_load(1, 0, 1'b0);
        next_tick(c); check(c == FD, "R8", c, FD);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(tick == 1'b0, "R1 in reset", int'(tick), 0);
        rst_n = 1'b1;
        t_reset_R1();
        t_full_R2();
        t_fast_R3();
        t_int_R4(5);
        t_int_R4(2);
        t_frac_R5(3, 1);
        t_frac_R5(2, 4);
        t_frac_R5(5, 7);
        t_wide_R6();
        t_pulse_R7();
        t_reload_R8();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule